// File: doc/BRIEF.md
# Command-Word I2C Master Engine

This block is an I2C bus master that runs one bus segment per command. The host writes a 32-bit control word. The word gives the byte count and the direction, and it says whether to open with a START, whether to close with a STOP and whether to keep SCL low once the last byte is done. For reads, it can also ask the engine to refuse the final byte. A separate 32-bit data word supplies up to four bytes to transmit, and a receive word collects up to four bytes. In both words the low byte travels first.

A complete bus transaction is built as a chain of segments. A typical read is an address segment that opens with START, sends a count of one and holds the clock, followed by a read segment that receives the bytes and closes with STOP. A typical write is a single segment whose count includes the address byte.

If a slave refuses a transmitted byte, the engine freezes with SCL held low. It stays frozen until the host pulses the NAK-clear input, and then it releases the bus with a STOP. A free-running quarter-bit tick generator paces all bus phases. A line monitor derives bus-busy from the START and STOP conditions it sees on SCL and SDA.

Top module: `i2c_cmd_master`

## Requirements
- R1: The control word is decoded as follows:
  - bits 15:0 are the byte count;
  - bit 16 is direction (1 = transmit);
  - bit 17 is master enable;
  - bit 19 requests START;
  - bit 20 requests STOP;
  - bit 21 requests clock hold;
  - bit 25 requests NAK on the last received byte;
  - bit 29 is run.

  A write with bit 29 set raises `run_o` on the next cycle. `run_o` stays high until the segment ends, and `done_o` pulses for one cycle when it falls.
- R2: On transmit, byte i of a segment is taken from bits 8*(i mod 4)+7 : 8*(i mod 4) of the data word and is shifted out MSB first.
- R3: On receive, byte i is stored in bits 8*i+7 : 8*i of `rx_data_o`. The receive word is cleared at launch, so lanes not reached read 0.
- R4: With the START flag set, a START condition precedes the first byte. This works from an idle bus and, as a repeated START, from a held clock. Without the flag, bits begin directly. SCL falls (START flag ? 1 : 0) + 9 × count times per segment.
- R5: A segment that ends without STOP keeps SCL driven low if the hold flag is set. Otherwise it releases both SCL and SDA without a STOP, and `bus_busy_o` stays high.
- R6: With the STOP flag set, the segment ends with a STOP condition, after which SCL and SDA are released and `bus_busy_o` falls.
- R7: A transmitted byte answered with NAK sets `got_nak_o`. `run_o` then stays high, SCL stays driven low and no further byte is sent until `nak_clr` pulses. The pulse clears `got_nak_o`, issues a STOP and ends the segment.
- R8: On receive, every byte is ACKed, except that the last byte is NAKed when bit 25 is set.
- R9: `bus_busy_o` rises on a START seen on the lines (SDA falling while SCL is high) and falls on a STOP seen on the lines (SDA rising while SCL is high).
- R10: `clk_busy_o` is high while the engine sequences bus phases. It is low when idle and while frozen on a NAK.
- R11: While `run_o` is high, control and data writes are ignored, and the running segment is unchanged.
- R12: A launch with count 0, or with master enable clear, pulses `done_o` on the next cycle and never raises `run_o`. It produces no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| data_we | input | 1 | Transmit data word write strobe |
| data_wdata | input | 32 | Transmit data word, low byte first |
| nak_clr | input | 1 | Releases the engine from a NAK freeze |
| run_o | output | 1 | Segment in progress |
| done_o | output | 1 | One-cycle pulse at segment end |
| got_nak_o | output | 1 | Slave refused a transmitted byte |
| bus_busy_o | output | 1 | Bus held between START and STOP |
| clk_busy_o | output | 1 | Engine is clocking the bus |
| rx_data_o | output | 32 | Received bytes, low byte first |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
A behavioural slave on the open-drain lines captures written bytes and counts the ACKs and NAKs it receives. The bench also counts every SCL falling edge. An engine that sends lanes in the wrong order or bit order would give the slave different bytes. A START issued on a continuation segment, or an extra clock, would show up as an off-by-one edge count. The bench checks a NAK freeze, a held clock versus a released clock, zero counts and writes made while a segment runs. Each of these exposes a specific fault: a design that kept clocking after a NAK, ACKed the last read byte, or let a mid-segment write retarget the running segment would change the slave's byte log or the edge count.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int CW_RUN   = 29;
    localparam int CW_NAKL  = 25;
    localparam int CW_HOLD  = 21;
    localparam int CW_STOP  = 20;
    localparam int CW_START = 19;
    localparam int CW_MST   = 17;
    localparam int CW_DIR   = 16;
    localparam int CNT_W    = 16;

    typedef struct packed {
        logic             naklast;
        logic             hold;
        logic             stop;
        logic             start;
        logic             master;
        logic             dir;
        logic [CNT_W-1:0] count;
    } seg_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_STOP,
        ST_REL,
        ST_NAKW
    } eng_state_t;

    function automatic seg_cmd_t decode_cmd(input logic [31:0] w);
        seg_cmd_t c;
        c.naklast = w[CW_NAKL];
        c.hold    = w[CW_HOLD];
        c.stop    = w[CW_STOP];
        c.start   = w[CW_START];
        c.master  = w[CW_MST];
        c.dir     = w[CW_DIR];
        c.count   = w[CNT_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/i2c_cmd_tick.sv
module i2c_cmd_tick #(
    parameter int QTR_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (QTR_CYC < 2) ? 1 : $clog2(QTR_CYC);

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(QTR_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= tick ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/i2c_cmd_busmon.sv
module i2c_cmd_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    logic scl_q, sda_q;
    logic start_seen, stop_seen;

    assign start_seen = scl_q && scl_i && sda_q && !sda_i;
    assign stop_seen  = scl_q && scl_i && !sda_q && sda_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            if (start_seen)     busy <= 1'b1;
            else if (stop_seen) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_cmd_lanes.sv
module i2c_cmd_lanes #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_we,
    input  logic [8*LANES-1:0] tx_wdata,
    input  logic [LW-1:0]      lane_sel,
    output logic [7:0]         tx_byte,
    input  logic               rx_clr,
    input  logic               rx_we,
    input  logic [7:0]         rx_byte,
    output logic [8*LANES-1:0] rx_word
);
    localparam int LW = $clog2(LANES);

    logic [7:0] tx_q [LANES];
    logic [7:0] rx_q [LANES];

    assign tx_byte = tx_q[lane_sel];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                tx_q[g] <= '0;
                rx_q[g] <= '0;
            end else begin
                if (tx_we) tx_q[g] <= tx_wdata[8*g +: 8];
                if (rx_clr) rx_q[g] <= '0;
                else if (rx_we && lane_sel == LW'(g)) rx_q[g] <= rx_byte;
            end
        end
        assign rx_word[8*g +: 8] = rx_q[g];
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int QTR_CYC = 4,
    parameter int LANES   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_we,
    input  logic [31:0] ctrl_wdata,
    input  logic        data_we,
    input  logic [31:0] data_wdata,
    input  logic        nak_clr,
    output logic        run_o,
    output logic        done_o,
    output logic        got_nak_o,
    output logic        bus_busy_o,
    output logic        clk_busy_o,
    output logic [31:0] rx_data_o,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe_o,
    output logic        sda_oe_o
);
    localparam int LW = $clog2(LANES);

    seg_cmd_t   cmd_in, ctl_q;
    eng_state_t state;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [CNT_W-1:0] bidx;
    logic [7:0] sh;
    logic       scl_low, sda_low, got_nak, done_q, run_q, ack_nak;
    logic       tick, launch, last_byte, rx_we;
    logic [7:0] tx_byte;
    logic [2:0] bsel;
    logic       unused_ctrl_bits;

    assign cmd_in    = decode_cmd(ctrl_wdata);
    assign launch    = ctrl_we && ctrl_wdata[CW_RUN] && !run_q;
    assign last_byte = (bidx == ctl_q.count - CNT_W'(1));
    assign bsel      = 3'd7 - bitn[2:0];
    assign rx_we     = tick && (state == ST_BIT) && (ph == 2'd3) && (bitn == 4'd8) && !ctl_q.dir;
    assign unused_ctrl_bits = ^{ctrl_wdata[31:30], ctrl_wdata[28:26], ctrl_wdata[24:22], ctrl_wdata[18]};

    i2c_cmd_tick #(.QTR_CYC(QTR_CYC)) i_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    i2c_cmd_busmon i_busmon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .busy(bus_busy_o)
    );

    i2c_cmd_lanes #(.LANES(LANES)) i_lanes (
        .clk(clk), .rst(rst),
        .tx_we(data_we && !run_q), .tx_wdata(data_wdata[8*LANES-1:0]),
        .lane_sel(bidx[LW-1:0]), .tx_byte(tx_byte),
        .rx_clr(launch), .rx_we(rx_we), .rx_byte(sh),
        .rx_word(rx_data_o[8*LANES-1:0])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ph      <= '0;
            bitn    <= '0;
            bidx    <= '0;
            sh      <= '0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            got_nak <= 1'b0;
            done_q  <= 1'b0;
            run_q   <= 1'b0;
            ack_nak <= 1'b0;
            ctl_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (ctrl_we && !run_q) ctl_q <= cmd_in;
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        if (cmd_in.count == '0 || !cmd_in.master) begin
                            done_q <= 1'b1;
                        end else begin
                            run_q <= 1'b1;
                            bidx  <= '0;
                            bitn  <= '0;
                            ph    <= '0;
                            state <= cmd_in.start ? ST_START : ST_BIT;
                        end
                    end
                end
                ST_NAKW: begin
                    if (nak_clr) begin
                        got_nak <= 1'b0;
                        ph      <= '0;
                        state   <= ST_STOP;
                    end
                end
                default: begin
                    if (tick) begin
                        ph <= ph + 2'd1;
                        case (state)
                            ST_START: begin
                                case (ph)
                                    2'd0: sda_low <= 1'b0;
                                    2'd1: scl_low <= 1'b0;
                                    2'd2: sda_low <= 1'b1;
                                    default: begin
                                        scl_low <= 1'b1;
                                        state   <= ST_BIT;
                                    end
                                endcase
                            end
                            ST_BIT: begin
                                case (ph)
                                    2'd0: begin
                                        if (!scl_low) begin
                                            scl_low <= 1'b1;
                                            ph      <= ph;
                                        end else if (bitn == 4'd8)
                                            sda_low <= !ctl_q.dir && !(ctl_q.naklast && last_byte);
                                        else
                                            sda_low <= ctl_q.dir && !tx_byte[bsel];
                                    end
                                    2'd1: scl_low <= 1'b0;
                                    2'd2: begin
                                        if (bitn == 4'd8) ack_nak <= sda_i;
                                        else              sh <= {sh[6:0], sda_i};
                                    end
                                    default: begin
                                        scl_low <= 1'b1;
                                        if (bitn != 4'd8) begin
                                            bitn <= bitn + 4'd1;
                                        end else begin
                                            bitn <= '0;
                                            if (ctl_q.dir && ack_nak) begin
                                                got_nak <= 1'b1;
                                                state   <= ST_NAKW;
                                            end else if (last_byte) begin
                                                if (ctl_q.stop) begin
                                                    state <= ST_STOP;
                                                end else if (ctl_q.hold) begin
                                                    sda_low <= 1'b0;
                                                    run_q   <= 1'b0;
                                                    done_q  <= 1'b1;
                                                    state   <= ST_IDLE;
                                                end else begin
                                                    state <= ST_REL;
                                                end
                                            end else begin
                                                bidx <= bidx + CNT_W'(1);
                                            end
                                        end
                                    end
                                endcase
                            end
                            ST_STOP: begin
                                case (ph)
                                    2'd0: sda_low <= 1'b1;
                                    2'd1: scl_low <= 1'b0;
                                    default: begin
                                        sda_low <= 1'b0;
                                        run_q   <= 1'b0;
                                        done_q  <= 1'b1;
                                        ph      <= '0;
                                        state   <= ST_IDLE;
                                    end
                                endcase
                            end
                            ST_REL: begin
                                if (ph == 2'd0) begin
                                    sda_low <= 1'b0;
                                end else begin
                                    scl_low <= 1'b0;
                                    run_q   <= 1'b0;
                                    done_q  <= 1'b1;
                                    ph      <= '0;
                                    state   <= ST_IDLE;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    assign run_o      = run_q;
    assign done_o     = done_q;
    assign got_nak_o  = got_nak;
    assign clk_busy_o = (state != ST_IDLE) && (state != ST_NAKW);
    assign scl_oe_o   = scl_low;
    assign sda_oe_o   = sda_low;

    if (LANES < 4) begin : g_rx_pad
        assign rx_data_o[31:8*LANES] = '0;
    end

    // R12
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && launch && cmd_in.count == '0) |=> (done_q && !run_q));

    // R7
    nak_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        got_nak |-> (run_q && scl_low));

    // R11
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && ctrl_we) |=> $stable(ctl_q));

    // R1
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> done_q);

    // R10
    clk_busy_run_chk: assert property (@(posedge clk) disable iff (rst)
        clk_busy_o |-> run_q);

    // R2
    sda_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT && !$stable(sda_low)) |-> ($past(scl_low) && scl_low));

endmodule

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
    localparam logic [6:0] SLV = 7'h50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        ctrl_we = 1'b0, data_we = 1'b0, nak_clr = 1'b0;
    logic [31:0] ctrl_wdata = '0, data_wdata = '0;
    logic        run_o, done_o, got_nak_o, bus_busy_o, clk_busy_o, scl_oe, sda_oe;
    logic [31:0] rx_data_o;
    logic        scl_line, sda_line, s_drive;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || s_drive);

    i2c_cmd_master i_i2c_cmd_master (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .nak_clr(nak_clr),
        .run_o(run_o), .done_o(done_o), .got_nak_o(got_nak_o),
        .bus_busy_o(bus_busy_o), .clk_busy_o(clk_busy_o), .rx_data_o(rx_data_o),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
    );

    // behavioural slave: 0 idle, 1 address, 2 write, 3 read, 4 refused, 5 read pending
    int mode = 0, bcnt = 0, rd_ptr = 0;
    int s_rx_n = 0, s_acks = 0, s_naks = 0, falls = 0, dones = 0;
    logic [7:0] sh = '0, cur = '0;
    logic [7:0] s_rx [16];
    logic scl_p = 1'b1, sda_p = 1'b1;
    initial s_drive = 1'b0;

    always @(posedge clk) begin
        if (done_o) dones++;
        if (scl_p && !scl_line) falls++;
        if (scl_line && scl_p && sda_p && !sda_line) begin
            mode = 1; bcnt = 0; s_drive = 1'b0;
        end else if (scl_line && scl_p && !sda_p && sda_line) begin
            mode = 0; s_drive = 1'b0;
        end else if (scl_line && !scl_p) begin
            if (mode != 0) begin
                bcnt++;
                if (bcnt <= 8) sh = {sh[6:0], sda_line};
                else if (mode == 3) begin
                    if (sda_line) begin s_naks++; mode = 4; end
                    else s_acks++;
                end
            end
        end else if (!scl_line && scl_p && mode != 0 && mode != 4) begin
            if (bcnt == 8) begin
                if (mode == 1) begin
                    if (sh[7:1] == SLV) begin
                        s_drive = 1'b1; mode = sh[0] ? 5 : 2; rd_ptr = 0;
                    end else begin
                        s_drive = 1'b0; mode = 0;
                    end
                end else if (mode == 2) begin
                    s_rx[s_rx_n[3:0]] = sh; s_rx_n++; s_drive = 1'b1;
                end else s_drive = 1'b0;
            end else if (bcnt == 9) begin
                bcnt = 0; s_drive = 1'b0;
                if (mode == 3 || mode == 5) begin
                    mode = 3; cur = 8'hC0 + 8'(rd_ptr); rd_ptr++; s_drive = !cur[7];
                end
            end else if (mode == 3 && bcnt >= 1 && bcnt <= 7) begin
                s_drive = !cur[7 - bcnt];
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit st, bit sp, bit hd, bit dr, bit nl, bit ms, logic [15:0] cnt);
        logic [31:0] w = '0;
        w[29] = 1'b1; w[25] = nl; w[21] = hd; w[20] = sp; w[19] = st;
        w[17] = ms; w[16] = dr; w[15:0] = cnt;
        return w;
    endfunction

    task automatic launch(input logic [31:0] cmd, input logic [31:0] data);
        @(negedge clk); data_we = 1'b1; data_wdata = data;
        @(negedge clk); data_we = 1'b0; falls = 0; ctrl_we = 1'b1; ctrl_wdata = cmd;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wait_done();
        while (run_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_seg(input logic [31:0] cmd, input logic [31:0] data);
        int d0 = dones;
        launch(cmd, data);
        chk("R1 run raised after launch", 32'(run_o), 32'd1);
        wait_done();
        chk("R1 one done pulse", 32'(dones - d0), 32'd1);
    endtask

    function automatic logic [31:0] exp_rx(int n);
        logic [31:0] e = '0;
        for (int k = 0; k < n; k++) e[8*k +: 8] = 8'hC0 + 8'(k);
        return e;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        int n, d0;
        logic [31:0] w;
        void'($urandom(32'd7341));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset run", 32'(run_o), 0);
        chk("R1 reset nak", 32'(got_nak_o), 0);
        chk("R9 reset busy", 32'(bus_busy_o), 0);
        chk("R10 reset clk busy", 32'(clk_busy_o), 0);
        chk("R6 reset lines", {30'd0, scl_oe, sda_oe}, 0);
        chk("R3 reset rx", rx_data_o, 0);

        // R2 R4 R6 random writes
        for (int i = 0; i < 6; i++) begin
            n = 1 + int'($urandom % 4);
            w = {$urandom} & 32'hFFFF_FF00 | 32'h0000_00A0;
            s_rx_n = 0;
            d0 = dones;
            launch(mk(1, 1, 0, 1, 0, 1, 16'(n)), w);
            repeat (40) @(negedge clk);
            chk("R9 busy mid segment", 32'(bus_busy_o), 1);
            chk("R10 clk busy mid segment", 32'(clk_busy_o), 1);
            wait_done();
            chk("R1 write done pulse", 32'(dones - d0), 1);
            chk("R2 byte count at slave", 32'(s_rx_n), 32'(n - 1));
            for (int j = 1; j < n; j++) chk("R2 byte order", 32'(s_rx[j-1]), 32'(w[8*j +: 8]));
            chk("R4 scl edges with start", 32'(falls), 32'(1 + 9*n));
            chk("R6 busy after stop", 32'(bus_busy_o), 0);
            chk("R6 lines released", {30'd0, scl_oe, sda_oe}, 0);
            chk("R10 clk busy idle", 32'(clk_busy_o), 0);
        end

        // R3 R5 R8 random reads
        for (int i = 0; i < 4; i++) begin
            n = 1 + int'($urandom % 4);
            s_acks = 0; s_naks = 0;
            run_seg(mk(1, 0, 1, 1, 0, 1, 16'd1), 32'h0000_00A1);
            chk("R5 clock held", 32'(scl_oe), 1);
            chk("R5 busy while held", 32'(bus_busy_o), 1);
            run_seg(mk(0, 1, 0, 0, 1, 1, 16'(n)), 32'h0);
            chk("R3 rx packing", rx_data_o, exp_rx(n));
            chk("R8 acks", 32'(s_acks), 32'(n - 1));
            chk("R8 last nak", 32'(s_naks), 1);
            chk("R4 no start edges", 32'(falls), 32'(9*n));
            chk("R6 busy after read stop", 32'(bus_busy_o), 0);
        end

        // R8 nak-on-last clear
        s_acks = 0; s_naks = 0;
        run_seg(mk(1, 0, 1, 1, 0, 1, 16'd1), 32'h0000_00A1);
        run_seg(mk(0, 1, 0, 0, 0, 1, 16'd2), 32'h0);
        chk("R8 all acked", 32'(s_acks), 2);
        chk("R8 no nak", 32'(s_naks), 0);
        chk("R3 two bytes", rx_data_o, exp_rx(2));

        // R7 refused address
        launch(mk(1, 1, 0, 1, 0, 1, 16'd2), 32'h0000_1166);
        while (!got_nak_o) @(negedge clk);
        repeat (200) @(negedge clk);
        chk("R7 run held", 32'(run_o), 1);
        chk("R7 scl held", 32'(scl_oe), 1);
        chk("R7 nak flag", 32'(got_nak_o), 1);
        chk("R7 no further bytes", 32'(falls), 10);
        chk("R10 clk busy frozen", 32'(clk_busy_o), 0);
        @(negedge clk); nak_clr = 1'b1;
        @(negedge clk); nak_clr = 1'b0;
        wait_done();
        chk("R7 nak cleared", 32'(got_nak_o), 0);
        chk("R7 stop after clear", 32'(bus_busy_o), 0);
        chk("R7 run cleared", 32'(run_o), 0);

        // R5 release without stop
        run_seg(mk(1, 0, 0, 1, 0, 1, 16'd1), 32'h0000_00A0);
        chk("R5 lines released", {30'd0, scl_oe, sda_oe}, 0);
        chk("R5 busy kept", 32'(bus_busy_o), 1);
        run_seg(mk(1, 1, 0, 1, 0, 1, 16'd1), 32'h0000_00A0);
        chk("R9 busy after stop", 32'(bus_busy_o), 0);

        // R12 zero count and master disabled
        for (int i = 0; i < 2; i++) begin
            d0 = dones;
            @(negedge clk); falls = 0; ctrl_we = 1'b1;
            ctrl_wdata = (i == 0) ? mk(1, 1, 0, 1, 0, 1, 16'd0) : mk(1, 1, 0, 1, 0, 0, 16'd3);
            @(negedge clk); ctrl_we = 1'b0;
            chk("R12 run stays low", 32'(run_o), 0);
            repeat (50) @(negedge clk);
            chk("R12 done once", 32'(dones - d0), 1);
            chk("R12 no bus edges", 32'(falls), 0);
            chk("R12 lines idle", {30'd0, scl_oe, sda_oe}, 0);
        end

        // R11 writes during a segment
        s_rx_n = 0;
        launch(mk(1, 1, 0, 1, 0, 1, 16'd2), 32'h0000_5AA0);
        repeat (20) @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = mk(1, 1, 0, 1, 0, 1, 16'd4);
        data_we = 1'b1; data_wdata = 32'hFFFF_FFFF;
        @(negedge clk); ctrl_we = 1'b0; data_we = 1'b0;
        wait_done();
        repeat (100) @(negedge clk);
        chk("R11 byte count", 32'(s_rx_n), 1);
        chk("R11 payload kept", 32'(s_rx[0]), 32'h5A);
        chk("R11 edges unchanged", 32'(falls), 19);
        chk("R11 no relaunch", 32'(run_o), 0);

        summary();
        $finish;
    end
endmodule